// File: doc/BRIEF.md
# Write-Only Serial Host Receiver

This block takes the four-wire write stream a host microcontroller sends to a display controller and turns it into whole 8-bit words. The host drives a serial clock and a data line, and the block shifts in one bit on each rising edge of that clock. After eight bits it hands the word to the controller core with a one-cycle strobe. A register-select line marks each word as pixel data or as a command.

The link only runs while both chip selects are at their active levels: the active-low select low and the active-high select high. Whenever that pair is not valid, the partial word and the bit counter are held cleared. A host can therefore recover from a broken transfer by deselecting the device. All host pins are asynchronous to the system clock. They pass through a shared two-flop synchroniser, and serial-clock edges are found by comparing the synchronised level with its previous value.

Top module: `serial_host_rx`

## Requirements
- R1: After reset, `byte_vld_o`, `byte_o` and `is_data_o` are all 0.
- R2: The link is selected only when `sel_n_i` is 0 and `sel_i` is 1. Serial clock edges seen while it is not selected produce no strobe and leave `byte_o` and `is_data_o` unchanged.
- R3: Deselecting clears any partially received word and the bit count, so the next selected transfer starts again at bit 7. If a deselect arrives together with the eighth rising edge, the deselect wins and no word is delivered.
- R4: `sdi_i` is sampled at the rising edge of `sck_i`. Changes to `sdi_i` while `sck_i` is high have no effect.
- R5: Bits arrive most significant first. The first bit received lands in `byte_o[7]` and the eighth in `byte_o[0]`.
- R6: `is_data_o` takes the level of `rs_i` at the eighth rising edge: 1 means display data and 0 means command. The `rs_i` level during the earlier seven bits is ignored.
- R7: Each completed word raises `byte_vld_o` for exactly one system-clock cycle. `byte_o` and `is_data_o` are valid in that cycle and hold their values until the next word completes.
- R8: After eight bits the counter wraps to zero, so consecutive words can follow without deselecting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Active-low chip select |
| sel_i | input | 1 | Active-high chip select |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| rs_i | input | 1 | Register select: 1 = display data, 0 = command |
| byte_vld_o | output | 1 | One-cycle strobe for a completed word |
| byte_o | output | 8 | Last completed word |
| is_data_o | output | 1 | Tag of the last completed word |

## Verification
Completion of a word and the clearing caused by deselect can land in the same system-clock cycle. Because the select lines and the serial clock share one synchroniser, the bench raises the eighth serial clock and drops the select at the same instant, so both reach the assembler on the same edge. The expected result is that no strobe appears. A full word sent after reselecting must then arrive intact, with exactly one strobe and no leftover bits from the aborted word.

// File: rtl/shrx_pkg.sv
package shrx_pkg;
    localparam int unsigned WORD_W = 8;
    localparam int unsigned CNT_W  = $clog2(WORD_W);
    localparam int unsigned PIN_N  = 5;

    typedef struct packed {
        logic [WORD_W-1:0] shift;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] word;
        logic              tag;
        logic              vld;
    } asm_state_t;

    typedef struct packed {
        logic sck_prev;
        logic rise;
        logic active;
    } edge_state_t;
endpackage

// File: rtl/shrx_sync.sv
module shrx_sync #(
    parameter int unsigned          W      = 1,
    parameter int unsigned          STAGES = 2,
    parameter logic [W-1:0]         RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] pipe_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[0] <= RST;
                else        pipe_q[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[s] <= RST;
                else        pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/shrx_edge.sv
module shrx_edge
    import shrx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic sel_n_s,
    input  logic sel_s,
    output logic rise_o,
    output logic active_o
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = sck_s;
        st_d.rise     = sck_s & ~st_q.sck_prev;
        st_d.active   = ~sel_n_s & sel_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o   = st_q.rise;
    assign active_o = st_q.active;
endmodule

// File: rtl/shrx_assembler.sv
module shrx_assembler
    import shrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              rise_i,
    input  logic              bit_i,
    input  logic              rs_i,
    output logic              vld_o,
    output logic [WORD_W-1:0] word_o,
    output logic              tag_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    asm_state_t st_d, st_q;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        shifted  = {st_q.shift[WORD_W-2:0], bit_i};
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!active_i) begin
            st_d.shift = '0;
            st_d.cnt   = '0;
        end else if (rise_i) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.shift = '0;
                st_d.cnt   = '0;
                st_d.word  = shifted;
                st_d.tag   = rs_i;
                st_d.vld   = 1'b1;
            end else begin
                st_d.shift = shifted;
                st_d.cnt   = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign word_o = st_q.word;
    assign tag_o  = st_q.tag;
    assign cnt_o  = st_q.cnt;
endmodule

// File: rtl/serial_host_rx.sv
module serial_host_rx
    import shrx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_i,
    input  logic              sel_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic              rs_i,
    output logic              byte_vld_o,
    output logic [WORD_W-1:0] byte_o,
    output logic              is_data_o
);
    logic [PIN_N-1:0] pins_raw, pins_s;
    logic sck_s, sdi_s, rs_s, sel_n_s, sel_s;
    logic sck_rise, sel_active;
    logic [CNT_W-1:0] asm_cnt;

    assign pins_raw = {sck_i, sdi_i, rs_i, sel_n_i, sel_i};

    shrx_sync #(
        .W      (PIN_N),
        .STAGES (SYNC_STAGES),
        .RST    (PIN_N'(5'b00010))
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    assign {sck_s, sdi_s, rs_s, sel_n_s, sel_s} = pins_s;

    // Data and select travel one cycle behind the pins too, so the
    // edge strobe and the sampled bit stay aligned.
    logic sdi_d, sdi_q, rs_d, rs_q;
    always_comb begin
        sdi_d = sdi_s;
        rs_d  = rs_s;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdi_q <= 1'b0;
            rs_q  <= 1'b0;
        end else begin
            sdi_q <= sdi_d;
            rs_q  <= rs_d;
        end
    end

    shrx_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_s    (sck_s),
        .sel_n_s  (sel_n_s),
        .sel_s    (sel_s),
        .rise_o   (sck_rise),
        .active_o (sel_active)
    );

    shrx_assembler u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (sel_active),
        .rise_i   (sck_rise),
        .bit_i    (sdi_q),
        .rs_i     (rs_q),
        .vld_o    (byte_vld_o),
        .word_o   (byte_o),
        .tag_o    (is_data_o),
        .cnt_o    (asm_cnt)
    );
endmodule

// File: rtl/shrx_checker.sv
module shrx_checker
    import shrx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              active,
    input logic              rise,
    input logic              rs_s,
    input logic [CNT_W-1:0]  cnt,
    input logic              vld,
    input logic [WORD_W-1:0] word,
    input logic              tag
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld); // R7

    AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |-> ($stable(word) && $stable(tag))); // R7

    AST_STROBE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> ($past(cnt) == LAST && $past(active) && $past(rise))); // R2

    AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt == '0 && !vld)); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rise && cnt != LAST) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R8

    AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rise && cnt == LAST) |=> (cnt == '0 && vld)); // R8

    AST_TAG_FROM_RS: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (tag == $past(rs_s, 2))); // R6
endmodule

bind serial_host_rx shrx_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (sel_active),
    .rise   (sck_rise),
    .rs_s   (rs_s),
    .cnt    (asm_cnt),
    .vld    (byte_vld_o),
    .word   (byte_o),
    .tag    (is_data_o)
);

// File: tb/tb_serial_host_rx.sv
`timescale 1ns/1ps
module tb_serial_host_rx;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic sel_n_i, sel_i, sck_i, sdi_i, rs_i;
    logic byte_vld_o, is_data_o;
    logic [7:0] byte_o;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    logic [7:0] seen_byte = '0;
    logic       seen_tag  = 1'b0;

    always #2 clk = ~clk;

    serial_host_rx dut (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n_i), .sel_i(sel_i),
        .sck_i(sck_i), .sdi_i(sdi_i), .rs_i(rs_i),
        .byte_vld_o(byte_vld_o), .byte_o(byte_o), .is_data_o(is_data_o)
    );

    always @(negedge clk) begin
        if (rst_n === 1'b1 && byte_vld_o === 1'b1) begin
            pulses    = pulses + 1;
            seen_byte = byte_o;
            seen_tag  = is_data_o;
        end
    end

    function automatic logic [7:0] model_word(input logic [7:0] bits_first_to_last);
        logic [7:0] acc = '0;
        for (int i = 0; i < 8; i++) acc = {acc[6:0], bits_first_to_last[7-i]};
        return acc;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b, input logic rs, input logic drop_sel);
        @(negedge clk);
        sdi_i = b;
        rs_i  = rs;
        idle(HALF);
        sck_i = 1'b1;
        if (drop_sel) sel_n_i = 1'b1;
        idle(4);
        sdi_i = ~b;
        rs_i  = ~rs;
        idle(HALF - 4);
        sck_i = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input int n, input logic rs_last, input logic drop_last);
        for (int i = 0; i < n; i++) begin
            if (i == n - 1) clock_bit(b[7-i], rs_last, drop_last);
            else            clock_bit(b[7-i], 1'($urandom % 2), 1'b0);
        end
    endtask

    task automatic expect_word(input string req, input int base, input int exp_pulses,
                               input logic [7:0] exp_b, input logic exp_tag);
        idle(12);
        chk({req, " strobe count"}, 32'(pulses - base), 32'(exp_pulses));
        if (exp_pulses > 0) begin
            chk({req, " word"}, {24'd0, seen_byte}, {24'd0, exp_b});
            chk({req, " tag"}, {31'd0, seen_tag}, {31'd0, exp_tag});
        end
    endtask

    task automatic reselect();
        sel_n_i = 1'b0;
        sel_i   = 1'b1;
        idle(8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int base;
        logic [7:0] w;
        logic t;
        void'($urandom(32'd2024));
        rst_n = 1'b0; sel_n_i = 1'b1; sel_i = 1'b0;
        sck_i = 1'b0; sdi_i = 1'b0; rs_i = 1'b0;
        idle(5);
        chk("R1 strobe", {31'd0, byte_vld_o}, 32'd0);
        chk("R1 word", {24'd0, byte_o}, 32'd0);
        chk("R1 tag", {31'd0, is_data_o}, 32'd0);
        rst_n = 1'b1;
        idle(4);
        reselect();

        // R5 R4 R6: directed words, sdi and rs flipped while sck is high
        base = pulses; send(8'hA5, 8, 1'b1, 1'b0);
        expect_word("R5 R4 R6 A5/data", base, 1, model_word(8'hA5), 1'b1);
        base = pulses; send(8'h3C, 8, 1'b0, 1'b0);
        expect_word("R5 R6 3C/cmd", base, 1, model_word(8'h3C), 1'b0);
        base = pulses; send(8'h80, 8, 1'b1, 1'b0);
        expect_word("R5 msb 80", base, 1, model_word(8'h80), 1'b1);

        // R2: clocks with either select inactive are ignored
        sel_n_i = 1'b1; idle(8);
        base = pulses; send(8'hFF, 8, 1'b0, 1'b0);
        expect_word("R2 sel_n high", base, 0, 8'h00, 1'b0);
        chk("R2 word held", {24'd0, byte_o}, 32'h80);
        sel_n_i = 1'b0; sel_i = 1'b0; idle(8);
        base = pulses; send(8'h0F, 8, 1'b0, 1'b0);
        expect_word("R2 sel low", base, 0, 8'h00, 1'b0);
        chk("R2 tag held", {31'd0, is_data_o}, 32'd1);
        reselect();
        base = pulses; send(8'h5A, 8, 1'b0, 1'b0);
        expect_word("R2 reselected 5A", base, 1, model_word(8'h5A), 1'b0);

        // R3: partial word discarded by deselect
        base = pulses; send(8'hF8, 5, 1'b1, 1'b0);
        sel_n_i = 1'b1; idle(8);
        reselect();
        send(8'h12, 8, 1'b1, 1'b0);
        expect_word("R3 partial cleared", base, 1, model_word(8'h12), 1'b1);

        // R3: deselect coincident with the eighth rising edge
        base = pulses; send(8'hE7, 7, 1'b1, 1'b0);
        clock_bit(1'b1, 1'b1, 1'b1);
        expect_word("R3 coincident deselect", base, 0, 8'h00, 1'b0);
        chk("R3 word untouched", {24'd0, byte_o}, 32'h12);
        idle(4); reselect();
        base = pulses; send(8'hC3, 8, 1'b0, 1'b0);
        expect_word("R3 after abort C3", base, 1, model_word(8'hC3), 1'b0);

        // R8 R7: random back-to-back words without deselect
        for (int k = 0; k < 20; k++) begin
            w = 8'($urandom);
            t = 1'($urandom % 2);
            base = pulses;
            send(w, 8, t, 1'b0);
            expect_word("R8 R7 stream", base, 1, model_word(w), t);
            idle(6);
            chk("R7 held between words", {24'd0, byte_o}, {24'd0, w});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule